// File: doc/BRIEF.md
# Quad SPI Flash Execute-in-Place Read Controller

This block fetches 32-bit words from a serial NOR flash over a four-line SPI link. It uses the quad I/O fast read. After the first read it leaves the flash in continuous read mode, so every later read starts with the address and skips the 8-clock command phase. The controller keeps one flag that records whether it believes the flash is in that mode.

A warm reset can leave the flash in continuous read mode while the controller has lost track of it. A command sent in that state would be taken as address bits. To avoid this, the controller makes no assumption after any reset. It first runs a recovery transaction that holds DQ0 high for a fixed number of SCK periods, which returns the flash to command mode from any state. Only after that does it serve reads, and the first of those carries the full command again.

On the bus side, the master holds `req` high with `addr` until it sees a one-cycle `ack` with `rdata`. SCK is a divided copy of the system clock, so a fast system clock can give a flash clock of 100 MHz or more.

Top module: `qspi_xip_reader`

## Requirements
- R1: While reset is asserted, and whenever `cs_n` is high, `sck` is 0 and `dq_oe` is 4'b0000. `ack` is 0 and `busy` is 1 during reset.
- R2: After reset is released, the first transaction is recovery. It lasts RECOVER_CLKS SCK periods (default 16), with `dq_oe`=4'b0001 and `dq_o[0]`=1 on every rising SCK edge. It leaves a flash in command mode whatever state the flash was in before.
- R3: The first read after recovery lasts 30 SCK periods, in this order:
  - 8 periods of command 0xEB on DQ0, MSB first, with `dq_oe`=4'b0001.
  - 6 periods of the 24-bit address on DQ3..DQ0, most significant nibble first, with `dq_oe`=4'b1111.
  - 2 periods of mode byte 0xA0, high nibble first, which keeps the flash in continuous mode.
  - 6 dummy periods with `dq_oe`=0.
  - 8 data periods with `dq_oe`=0.
- R4: Every later read, until the next reset, leaves out the command and lasts 22 SCK periods. No command bits are ever sent while the flash is in continuous mode.
- R5: The nibble sampled in data period k (k=0..7) lands in `rdata[31-4k -: 4]`, so the byte at `addr` sits in bits 31:24. `ack` is a single-cycle pulse, and `rdata` is valid in that cycle.
- R6: `busy` is high from the cycle after a read starts, and during pending recovery, until the transaction ends. `busy` is low in the `ack` cycle.
- R7: Between any two transactions, and before the first, `cs_n` stays high for at least CS_GAP system clocks (default 2).
- R8: Each SCK high phase and each SCK low phase lasts SCK_HALF system clocks. `cs_n` and `dq_o` change only while `sck` is low, and the flash samples them on the rising edge.
- R9: A reset asserted in the middle of a read aborts it. The controller then runs recovery followed by a full-command read, and that read returns correct data.
- R10: A request raised while `busy` is high, or during recovery, is held and served once the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held high until ack |
| addr | input | 24 | Byte address of the word to read |
| busy | output | 1 | Transfer or recovery in progress |
| ack | output | 1 | One-cycle pulse, rdata valid |
| rdata | output | 32 | Read word, first byte in bits 31:24 |
| sck | output | 1 | Flash serial clock, idles low |
| cs_n | output | 1 | Flash chip select, active low |
| dq_o | output | 4 | Data driven to the flash |
| dq_oe | output | 4 | Per-line output enable |
| dq_i | input | 4 | Data returned from the flash |

## Verification
The bench's flash model powers up in continuous mode, so the first transaction must be a real recovery. A controller that skipped recovery, or that sent the command anyway, would send 0xEB as address bits and read the wrong word. A reset in the middle of a read in continuous mode checks that the controller clears its mode flag. A design that kept the flag would skip the command while the flash expects it, and would return garbage. The model counts any command bits sent while it is in continuous mode, and the bench checks the length of every transaction, so a 30-clock read after the first one would be caught. The bench also checks nibble order at addresses 0x000000 and 0xFFFFFC, SCK phase widths with a divider of 2, and the minimum chip-select gap.

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader #(
  parameter int SCK_HALF = 1,
  parameter int RECOVER_CLKS = 16,
  parameter int CS_GAP = 2,
  parameter logic [7:0] READ_CMD = 8'hEB,
  parameter logic [7:0] STAY_MODE = 8'hA0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [23:0] addr,
  output logic        busy,
  output logic        ack,
  output logic [31:0] rdata,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  dq_o,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_i
);
  localparam int FULL_CLKS = 30;
  localparam int MAX_LEN = (RECOVER_CLKS > FULL_CLKS) ? RECOVER_CLKS : FULL_CLKS;
  localparam int SEQ_W = $clog2(MAX_LEN + 1) + 1;
  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam logic [SEQ_W-1:0] L_REC  = SEQ_W'(RECOVER_CLKS);
  localparam logic [SEQ_W-1:0] L_FULL = SEQ_W'(FULL_CLKS);
  localparam logic [SEQ_W-1:0] L_XIP  = SEQ_W'(FULL_CLKS - 8);
  localparam logic [SEQ_W-1:0] OFF    = SEQ_W'(8);
  localparam logic [SEQ_W-1:0] E_ADDR = SEQ_W'(8);
  localparam logic [SEQ_W-1:0] E_MODE = SEQ_W'(14);
  localparam logic [SEQ_W-1:0] E_DUMMY = SEQ_W'(16);
  localparam logic [SEQ_W-1:0] E_DATA = SEQ_W'(22);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
  localparam logic [GAP_W-1:0] GAP_N = GAP_W'(CS_GAP);

  logic             running, rec, need_rec, xip_on;
  logic [SEQ_W-1:0] seq, len, e;
  logic [DIV_W-1:0] dcnt;
  logic [GAP_W-1:0] gcnt;
  logic [23:0]      addr_q;
  logic [31:0]      sh;
  logic             gap_ok;

  assign len    = rec ? L_REC : (xip_on ? L_XIP : L_FULL);
  assign e      = (xip_on && !rec) ? seq + OFF : seq;
  assign gap_ok = gcnt >= GAP_N;
  assign busy   = running || need_rec;

  always_comb begin
    dq_o  = 4'b0000;
    dq_oe = 4'b0000;
    if (running && seq < len) begin
      if (rec) begin
        dq_oe = 4'b0001;
        dq_o  = 4'b0001;
      end else if (e < E_ADDR) begin
        dq_oe = 4'b0001;
        dq_o  = {3'b000, READ_CMD[3'd7 - e[2:0]]};
      end else if (e < E_MODE) begin
        dq_oe = 4'b1111;
        dq_o  = 4'(addr_q >> (5'd20 - {e[2:0], 2'b00}));
      end else if (e < E_DUMMY) begin
        dq_oe = 4'b1111;
        dq_o  = e[0] ? STAY_MODE[3:0] : STAY_MODE[7:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      rec      <= 1'b0;
      need_rec <= 1'b1;
      xip_on   <= 1'b0;
      seq      <= '0;
      dcnt     <= '0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      gcnt     <= '0;
      addr_q   <= '0;
      sh       <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
    end else begin
      ack  <= 1'b0;
      gcnt <= cs_n ? (gap_ok ? gcnt : gcnt + 1'b1) : '0;
      if (!running) begin
        if (gap_ok && (need_rec || req)) begin
          running <= 1'b1;
          rec     <= need_rec;
          cs_n    <= 1'b0;
          seq     <= '0;
          dcnt    <= '0;
          sck     <= 1'b0;
          if (!need_rec) addr_q <= addr;
        end
      end else if (dcnt != DIV_LAST) begin
        dcnt <= dcnt + 1'b1;
      end else begin
        dcnt <= '0;
        if (sck) begin
          sck <= 1'b0;
          seq <= seq + 1'b1;
        end else if (seq < len) begin
          sck <= 1'b1;
          if (!rec && e >= E_DATA) sh <= {sh[27:0], dq_i};
        end else begin
          running <= 1'b0;
          cs_n    <= 1'b1;
          if (rec) begin
            need_rec <= 1'b0;
          end else begin
            xip_on <= 1'b1;
            ack    <= 1'b1;
            rdata  <= sh;
          end
        end
      end
    end
  end
endmodule

// File: rtl/qspi_xip_reader_chk.sv
module qspi_xip_reader_chk #(
  parameter int CS_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ack,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] dq_o,
  input logic [3:0] dq_oe
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 0;
    else if (cs_n) hi_cnt <= (hi_cnt < CS_GAP) ? hi_cnt + 1 : hi_cnt;
    else hi_cnt <= 0;
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck && dq_oe == 4'b0000));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !busy);

  assert_ack_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(busy));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= CS_GAP);

  assert_cs_edge_sck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sck);

  assert_dq_change_sck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$stable(dq_o)) |-> !sck);
endmodule

bind qspi_xip_reader qspi_xip_reader_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack(ack), .sck(sck),
  .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe)
);

// File: tb/tb_qspi_xip_reader.sv
module tb_qspi_xip_reader;
  localparam int HALF = 2;
  localparam int REC = 16;
  localparam int GAP = 2;

  logic        clk = 0, rst_n = 0, req = 0;
  logic [23:0] addr = '0;
  logic        busy, ack, sck, cs_n;
  logic [31:0] rdata;
  logic [3:0]  dq_o, dq_oe, dq_i;

  always #4 clk = ~clk;

  qspi_xip_reader #(.SCK_HALF(HALF), .RECOVER_CLKS(REC), .CS_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy), .ack(ack),
    .rdata(rdata), .sck(sck), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] expword(input logic [23:0] a);
    return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
  endfunction

  // behavioural flash, powers up in continuous read mode
  logic       m_xip = 1'b1;
  int         cnt = 0, t_off = 0, me = 0, me2 = 0, nib = 0;
  logic       ones = 0, all1 = 0, valid = 0;
  logic [7:0] cmd = 0, mb = 0, b = 0;
  logic [23:0] ma = 0;
  logic [3:0] fdrv = 0;
  logic       fen = 0;
  int         last_len = 0, prev_len = 0, txn_count = 0, cmd_in_xip = 0;
  logic       last_all1 = 0;
  logic [7:0] last_cmd = 0;

  assign dq_i = fen ? fdrv : 4'h0;

  always @(negedge cs_n) begin
    cnt = 0; ones = 1; all1 = 1; valid = 1; cmd = 0; fen = 0;
    t_off = m_xip ? 8 : 0;
  end

  always @(posedge sck) if (!cs_n) begin
    me = cnt + t_off;
    all1 = all1 & dq_o[0] & (dq_oe == 4'b0001);
    if (cnt < 8) ones = ones & dq_o[0];
    if (t_off == 8 && cnt < 8 && dq_oe == 4'b0001 && !dq_o[0]) cmd_in_xip++;
    if (me < 8) begin
      cmd = {cmd[6:0], dq_o[0]};
      if (me == 7 && cmd != 8'hEB) valid = 0;
    end else if (me < 14) ma = {ma[19:0], dq_o};
    else if (me < 16) mb = {mb[3:0], dq_o};
    cnt++;
  end

  always @(negedge sck) if (!cs_n) begin
    me2 = cnt + t_off;
    if (valid && me2 >= 22 && me2 < 30) begin
      nib = me2 - 22;
      b = fbyte(ma + 24'(nib / 2));
      fdrv = (nib % 2 == 0) ? b[7:4] : b[3:0];
      fen = 1;
    end else fen = 0;
  end

  always @(posedge cs_n) begin
    fen = 0;
    prev_len = last_len; last_len = cnt; last_all1 = all1; last_cmd = cmd;
    txn_count++;
    if (valid && cnt + t_off == 30) m_xip = (mb == 8'hA0);
    else if (cnt >= 8 && ones) m_xip = 0;
    cnt = 0; ones = 0; valid = 0;
  end

  // monitors
  int hi_run = 0, min_hi = 1000, max_hi = 0, cs_run = 0, min_gap = 1000;
  always @(negedge clk) begin
    if (sck) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < min_hi) min_hi = hi_run;
      if (hi_run > max_hi) max_hi = hi_run;
      hi_run = 0;
    end
    if (cs_n) cs_run++;
    else if (cs_run > 0) begin
      if (cs_run < min_gap) min_gap = cs_run;
      cs_run = 0;
    end
  end

  task automatic wait_ack(input string rq);
    int t = 0;
    while (!ack && t < 5000) begin @(negedge clk); t++; end
    chk(ack, rq, "ack seen", {31'd0, ack}, 32'd1);
  endtask

  task automatic do_read(input logic [23:0] a, input int exp_len, input string rq);
    bit saw_busy = 0;
    int t = 0;
    @(negedge clk); req = 1; addr = a;
    while (!ack && t < 5000) begin @(negedge clk); t++; if (busy) saw_busy = 1; end
    chk(ack, "R5", "ack seen", {31'd0, ack}, 32'd1);
    chk(rdata == expword(a), "R5", "read data", rdata, expword(a));
    chk(!busy, "R6", "busy low in ack cycle", {31'd0, busy}, 32'd0);
    chk(saw_busy, "R6", "busy during read", {31'd0, saw_busy}, 32'd1);
    chk(last_len == exp_len, rq, "transaction length", last_len, exp_len);
    req = 0;
    @(negedge clk);
    chk(!ack, "R5", "ack one cycle", {31'd0, ack}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cs_n, "R1", "cs_n in reset", {31'd0, cs_n}, 32'd1);
    chk(!sck, "R1", "sck in reset", {31'd0, sck}, 32'd0);
    chk(dq_oe == 4'h0, "R1", "dq_oe in reset", {28'd0, dq_oe}, 32'd0);
    chk(!ack && busy, "R1", "ack/busy in reset", {30'd0, ack, busy}, 32'd1);
  endtask

  task automatic t_recovery;
    int n0 = txn_count;
    int t = 0;
    rst_n = 1;
    while (txn_count == n0 && t < 2000) begin @(negedge clk); t++; end
    chk(last_len == REC, "R2", "recovery length", last_len, REC);
    chk(last_all1, "R2", "DQ0 high on every clock", {31'd0, last_all1}, 32'd1);
    chk(!m_xip, "R2", "flash in command mode", {31'd0, m_xip}, 32'd0);
    @(negedge clk);
    chk(!busy, "R6", "busy low after recovery", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_first_read;
    do_read(24'h000100, 30, "R3");
    chk(last_cmd == 8'hEB, "R3", "command byte", {24'd0, last_cmd}, 32'hEB);
    chk(m_xip, "R3", "flash entered continuous mode", {31'd0, m_xip}, 32'd1);
  endtask

  task automatic t_xip_reads;
    do_read(24'h000000, 22, "R4");
    do_read(24'hFFFFFC, 22, "R4");
    do_read(24'h123456, 22, "R4");
    do_read(24'hA5A5A4, 22, "R4");
  endtask

  task automatic t_mid_reset;
    int n0;
    @(negedge clk); req = 1; addr = 24'h0ABCDE;
    repeat (30) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    n0 = txn_count;
    rst_n = 1;
    wait_ack("R10");
    chk(rdata == expword(24'h0ABCDE), "R9", "data after mid reset", rdata, expword(24'h0ABCDE));
    chk(txn_count == n0 + 2, "R9", "recovery then read", txn_count, n0 + 2);
    chk(prev_len == REC, "R9", "recovery first", prev_len, REC);
    chk(last_len == 30, "R10", "held request served with command", last_len, 30);
    req = 0;
    @(negedge clk);
    do_read(24'h777770, 22, "R4");
  endtask

  task automatic t_final;
    chk(cmd_in_xip == 0, "R4", "command bits in continuous mode", cmd_in_xip, 0);
    chk(min_hi == HALF && max_hi == HALF, "R8", "sck high phase", max_hi, HALF);
    chk(min_gap >= GAP, "R7", "cs_n gap", min_gap, GAP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_recovery;
    t_first_read;
    t_xip_reads;
    t_mid_reset;
    t_final;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule